// File: doc/BRIEF.md
# Pipelined Q15 Fractional Divider

This block divides one signed Q15 fraction by another and returns the quotient truncated toward zero in Q15, together with the matching remainder. Both operands are 16-bit two's-complement numbers scaled by 2^15, so they lie in [-1, 1). The quotient is only representable when its magnitude stays inside that range. The dividend is pre-scaled by 2^15. The division then runs through sixteen add-or-subtract-and-shift stages whose quotient digits are drawn from {-1, +1}. A final stage converts those digits to plain binary. The same final stage repairs results whose partial remainder passed through zero, and it applies the sign fix that truncating division needs.

The recurrence is fully unrolled and registered at every stage. A new operation can enter on every clock, and each result leaves a fixed 17 cycles after its operands. Two flags come out with each result. One marks a zero divisor. The other marks a quotient that Q15 cannot hold. When either flag is set, the quotient and remainder carry no meaning.

Top module: `q15_nr_divider`

## Requirements
- R1: For a nonzero divisor whose exact quotient fits in Q15, `out_quot` equals (dividend × 2^15) / divisor, truncated toward zero, as a 16-bit two's-complement value.
- R2: In those same cases, `out_rem` equals dividend × 2^15 − quotient × divisor. It is zero or carries the sign of the dividend.
- R3: `out_valid` rises exactly 17 clock cycles after the cycle in which `in_valid` was sampled high, and the result it qualifies belongs to the operands of that cycle.
- R4: Operations presented on consecutive cycles each produce exactly one result, in the order they were presented, with no gaps inserted.
- R5: When the dividend is the exact negation of a nonzero divisor, with unequal bit patterns, the result is quotient 0x8000 (−1.0) and remainder 0. The overflow flag stays clear.
- R6: `out_ovf` is high exactly when the divisor is nonzero and the truncated quotient falls outside [−32768, 32767] in integer units. This happens when |dividend| ≥ |divisor|, except in the R5 case.
- R7: `out_dz` is high exactly when the divisor is 0x0000. `out_ovf` is never high together with it.
- R8: During and directly after a synchronous active-high reset, `out_valid` is low.
- R9: Exact divisions, where the remainder is zero, return the exact quotient and a zero remainder. This holds even though the recurrence steps past a zero partial remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle are to be divided |
| in_num | input | 16 | Dividend, signed Q15 |
| in_den | input | 16 | Divisor, signed Q15 |
| out_valid | output | 1 | Result outputs are meaningful this cycle |
| out_quot | output | 16 | Quotient, signed Q15, truncated toward zero |
| out_rem | output | 16 | Remainder of the scaled division, signed |
| out_ovf | output | 1 | Quotient not representable in Q15 |
| out_dz | output | 1 | Divisor was zero |

## Verification
The bench aims at exact divisions such as 0x2000 / 0x4000 and 0x7FFF / 0x8000. A design that skipped the zero-crossing repair would return those quotients one LSB off with a remainder equal to ±divisor. It also drives negative quotients with nonzero remainders; a missing or inverted sign fix shows up there as a quotient rounded away from zero and a remainder with the wrong sign. The boundary pairs 0x4000 / 0xC000, 0x8000 / 0x8000 and 0x5000 / 0x4000 separate the single representable −1.0 result from true overflow, which catches an overflow test that is too loose or too strict. Back-to-back random streams, mixed with zero divisors and idle gaps, expose stages that drop, duplicate or misalign operations.

// File: rtl/q15_nr_divider.sv
`timescale 1ns/1ps
module q15_nr_divider #(
  parameter int W    = 16,
  parameter int FRAC = W - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_num,
  input  logic [W-1:0] in_den,
  output logic         out_valid,
  output logic [W-1:0] out_quot,
  output logic [W-1:0] out_rem,
  output logic         out_ovf,
  output logic         out_dz
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] step_pp(input logic [PW-1:0] p, input logic [W-1:0] d);
    logic [PW-1:0] dd;
    dd = {d, {W{1'b0}}};
    return (p[PW-1] ^ d[W-1]) ? ((p << 1) + dd) : ((p << 1) - dd);
  endfunction

  logic          r_v  [1:W];
  logic [PW-1:0] r_pp [1:W];
  logic [W-1:0]  r_q  [1:W];
  logic [W-1:0]  r_a  [1:W];
  logic [W-1:0]  r_b  [1:W];

  logic          c_v  [0:W-1];
  logic [PW-1:0] c_pp [0:W-1];
  logic [W-1:0]  c_q  [0:W-1];
  logic [W-1:0]  c_a  [0:W-1];
  logic [W-1:0]  c_b  [0:W-1];

  always_comb begin
    c_v[0]  = in_valid;
    c_pp[0] = PW'(signed'(in_num)) << FRAC;
    c_q[0]  = '0;
    c_a[0]  = in_num;
    c_b[0]  = in_den;
    for (int i = 1; i < W; i++) begin
      c_v[i]  = r_v[i];
      c_pp[i] = r_pp[i];
      c_q[i]  = r_q[i];
      c_a[i]  = r_a[i];
      c_b[i]  = r_b[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      r_v[i+1]  <= rst ? 1'b0 : c_v[i];
      r_pp[i+1] <= step_pp(c_pp[i], c_b[i]);
      r_q[i+1]  <= {c_q[i][W-2:0], ~(c_pp[i][PW-1] ^ c_b[i][W-1])};
      r_a[i+1]  <= c_a[i];
      r_b[i+1]  <= c_b[i];
    end
  end

  logic [W-1:0] fa, fd, fnd, qc, r0, q1, r1;
  logic [W:0]   mag_a, mag_d;
  logic         dz, neg_one, ovf;

  assign fa    = r_a[W];
  assign fd    = r_b[W];
  assign fnd   = ~fd + 1'b1;
  assign qc    = {r_q[W][W-2:0], 1'b1};
  assign r0    = r_pp[W][PW-1:W];
  assign mag_a = {1'b0, fa[W-1] ? (~fa + 1'b1) : fa};
  assign mag_d = {1'b0, fd[W-1] ? fnd : fd};
  assign dz      = (fd == '0);
  assign neg_one = (fa == fnd) && (fa != fd);
  assign ovf     = !dz && (mag_a >= mag_d) && !neg_one;

  always_comb begin
    q1 = qc;
    r1 = r0;
    if (r0 == fd) begin
      q1 = qc + 1'b1;
      r1 = '0;
    end else if (r0 == fnd) begin
      q1 = qc - 1'b1;
      r1 = '0;
    end
    if ((r1 != '0) && (r1[W-1] ^ fa[W-1])) begin
      if (q1[W-1]) begin
        q1 = q1 + 1'b1;
        r1 = r1 - fd;
      end else begin
        q1 = q1 - 1'b1;
        r1 = r1 + fd;
      end
    end
  end

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : r_v[W];
    out_quot  <= q1;
    out_rem   <= r1;
    out_ovf   <= ovf;
    out_dz    <= dz;
  end
endmodule

module q15_nr_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_num,
  input logic [W-1:0] in_den,
  input logic         out_valid,
  input logic [W-1:0] out_quot,
  input logic [W-1:0] out_rem,
  input logic         out_ovf,
  input logic         out_dz
);
  localparam int LAT = W + 1;

  logic [LAT-1:0] vh, zh, sah, sbh;

  always_ff @(posedge clk) begin
    if (rst) begin
      vh <= '0; zh <= '0; sah <= '0; sbh <= '0;
    end else begin
      vh  <= {vh[LAT-2:0], in_valid};
      zh  <= {zh[LAT-2:0], in_den == '0};
      sah <= {sah[LAT-2:0], in_num[W-1]};
      sbh <= {sbh[LAT-2:0], in_den[W-1]};
    end
  end

  assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LAT-1]);

  assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dz == zh[LAT-1]));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ovf |-> !out_dz);

  assert_quot_sign_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ovf && !out_dz && (out_quot != '0)
      |-> out_quot[W-1] == (sah[LAT-1] ^ sbh[LAT-1]));

  assert_rem_sign_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ovf && !out_dz && (out_rem != '0)
      |-> out_rem[W-1] == sah[LAT-1]);
endmodule

bind q15_nr_divider q15_nr_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_num(in_num), .in_den(in_den),
  .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem),
  .out_ovf(out_ovf), .out_dz(out_dz)
);

// File: tb/q15_nr_divider_tb.sv
`timescale 1ns/1ps
module q15_nr_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_num = '0;
  logic [15:0] in_den = '0;
  logic        out_valid;
  logic [15:0] out_quot, out_rem;
  logic        out_ovf, out_dz;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] q_ops [$];
  int          q_cyc [$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  q15_nr_divider u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_num(in_num), .in_den(in_den),
    .out_valid(out_valid), .out_quot(out_quot), .out_rem(out_rem),
    .out_ovf(out_ovf), .out_dz(out_dz)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_num   = a;
    in_den   = b;
    q_ops.push_back({a, b});
    q_cyc.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_num   = 16'hDEAD;
      in_den   = 16'hBEEF;
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] op;
    int          c0;
    longint      n, bl, qt, rt;
    bit          e_ovf;
    string       tq;
    if (!rst && out_valid) begin
      if (q_ops.size() == 0) begin
        check(1'b0, "R4 unexpected result", 1, 0);
      end else begin
        op = q_ops.pop_front();
        c0 = q_cyc.pop_front();
        check(cyc - c0 == 17, "R3 latency", cyc - c0, 17);
        n  = longint'($signed(op[31:16])) * 32768;
        bl = longint'($signed(op[15:0]));
        check(out_dz == (bl == 0), "R7 divide-by-zero flag", out_dz, bl == 0);
        if (bl != 0) begin
          qt    = n / bl;
          rt    = n - qt * bl;
          e_ovf = (qt > 32767) || (qt < -32768);
          check(out_ovf == e_ovf, "R6 overflow flag", out_ovf, e_ovf);
          if (!e_ovf) begin
            tq = (qt == -32768) ? "R5 quotient -1" : (rt == 0) ? "R9 exact quotient" : "R1 quotient";
            check(out_quot == qt[15:0], tq, out_quot, qt[15:0]);
            check(out_rem == rt[15:0], "R2 remainder", out_rem, rt[15:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 valid low in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid low after reset", out_valid, 0);

    send(16'h4000, 16'h8000);
    send(16'h4000, 16'hC000);
    send(16'hC000, 16'h4000);
    send(16'h8000, 16'h8000);
    send(16'h5000, 16'h4000);
    send(16'h2000, 16'h4000);
    send(16'h7FFF, 16'h8000);
    send(16'h8001, 16'h8000);
    send(16'h0000, 16'h1234);
    send(16'h1234, 16'h0000);
    send(16'h0001, 16'h7FFF);
    send(16'h7FFE, 16'h7FFF);
    send(16'hFFFF, 16'h0003);
    send(16'h0001, 16'hFFFD);
    send(16'hE000, 16'h6000);
    idle(25);

    send(16'h1111, 16'h2222);
    idle(25);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (i % 3 != 0) a = 16'($signed(a) >>> (1 + i % 8));
      if (i % 37 == 0) b = '0;
      if (i % 41 == 0) a = 16'(-$signed(b));
      send(a, b);
      if (i % 50 == 49) idle(3);
    end
    idle(30);
    check(q_ops.size() == 0, "R4 all results returned", q_ops.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule